// File: doc/BRIEF.md
# Tuner Synthesizer Divider, Phase Detector and Lock Detector

This block is the digital core of a tuner frequency synthesizer. It counts strobes from a crystal reference and from the oscillator feedback path, divides each by its own ratio, and compares the two divided edges in a phase-frequency detector that produces `up_o` and `dn_o` pulses for an external charge pump. All logic runs on one system clock. The two inputs `ref_tick_i` and `fb_tick_i` are one-cycle strobes, one for each edge of the reference clock and of the feedback clock, already brought into the system clock domain.

The reference ratio comes from a 3-bit select. The feedback ratio is a 15-bit word with a floor of 512. A new ratio takes effect only when the running count ends, so a division period is never cut short. A lock detector measures how long the two detector outputs disagree in each comparison period. It raises `lock_o` after a run of clean periods and drops it as soon as one period goes over the limit.

A small decoder turns the pump-current select and a mode bit into a one-hot current select for the analog pump.

Top module: `synth_core`

## Requirements
- R1: The reference divider emits one `ref_pulse_o` every R accepted reference strobes, where `ref_sel_i` gives R as follows: 0 gives 24, 1 gives 28, 2 gives 32, 3 gives 64, 4 gives 128, and both 5 and 7 give 80.
- R2: `ref_sel_i` = 6 is reserved. It divides by 128 and drives `ref_rsv_o` high. `ref_rsv_o` is low for every other code.
- R3: The feedback divider emits one `fb_pulse_o` every N accepted feedback strobes, with N = `n_word_i`. Any word below 512 divides by 512, and the largest word, 32767, divides by 32767.
- R4: Each divider samples its ratio only at its terminal count. The first strobe after reset produces a pulse at once, and a ratio changed in the middle of a period takes effect from the following period.
- R5: A reference pulse sets `up_o` and a feedback pulse sets `dn_o`. Each stays high until both are high. Both are then high for exactly one cycle, then both clear, and pulses that arrive in that clearing cycle are ignored.
- R6: The error width of a period is the number of cycles in which exactly one of `up_o` and `dn_o` is high. `lock_o` rises after 4 consecutive periods whose width is at most `err_limit_i`. A width equal to the limit still counts as clean.
- R7: In the cycle in which the error width grows past `err_limit_i`, `lock_o` clears and the count of clean periods restarts. It does not wait for the period to end.
- R8: `pump_sel_o` is one-hot. Bit k is selected by `cp_sel_i[1:0]` = k for k = 0..3 (70, 140, 350 and 600 uA). When `cp_mode_i` = 0, `cp_sel_i[2]` is ignored.
- R9: When `cp_mode_i` = 1 and `cp_sel_i` = 3'b100, bit 4 (900 uA) is selected. Any other value with `cp_sel_i[2]` set falls back to the `cp_sel_i[1:0]` mapping.
- R10: While reset is asserted, `ref_pulse_o`, `fb_pulse_o`, `up_o`, `dn_o` and `lock_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_tick_i | input | 1 | One strobe per reference clock edge |
| fb_tick_i | input | 1 | One strobe per feedback clock edge |
| n_word_i | input | 15 | Feedback divide word |
| ref_sel_i | input | 3 | Reference ratio select |
| cp_sel_i | input | 3 | Pump current select |
| cp_mode_i | input | 1 | Enables the extended pump code |
| err_limit_i | input | 8 | Largest error width, in cycles, that still counts as clean |
| ref_pulse_o | output | 1 | Divided reference edge |
| fb_pulse_o | output | 1 | Divided feedback edge |
| up_o | output | 1 | Detector pump-up |
| dn_o | output | 1 | Detector pump-down |
| lock_o | output | 1 | Lock flag |
| ref_rsv_o | output | 1 | Reserved reference code in use |
| pump_sel_o | output | 5 | One-hot pump current select |

## Verification
The bench measures the spacing between divided pulses for every reference code, including the reserved code and the two codes that share 80. A decoder that mapped 7 anywhere other than 80, or 6 anywhere other than 128, shows up as a wrong gap. It also loads feedback words below the floor and at the top of the range, and changes a ratio in the middle of a period. A divider that reloads on every write, rather than at its terminal count, shortens the period that is running. The lock test sets the lag between the two edges in steps, first to exactly the limit and then to one cycle past it. A detector that used a strict comparison would never lock, and one that evaluated only at the end of a period would still show lock in the cycle where both outputs are high. The pump decoder is swept over all 16 select and mode combinations, so any use of the top select bit without the mode bit is caught.

// File: rtl/synth_pkg.sv
package synth_pkg;
  localparam int REF_W  = 8;
  localparam int PUMP_N = 5;

  // Reference ratio decode. Code 6 is reserved and treated as 128.
  function automatic logic [REF_W-1:0] ref_ratio(input logic [2:0] sel);
    logic [REF_W-1:0] r;
    case (sel)
      3'd0:    r = 8'd24;
      3'd1:    r = 8'd28;
      3'd2:    r = 8'd32;
      3'd3:    r = 8'd64;
      3'd4:    r = 8'd128;
      3'd6:    r = 8'd128;
      default: r = 8'd80;
    endcase
    return r;
  endfunction

  function automatic logic [PUMP_N-1:0] pump_onehot(input logic [2:0] cp, input logic mode);
    logic [PUMP_N-1:0] s;
    s = '0;
    if (mode && cp == 3'b100) s[4] = 1'b1;
    else                      s[cp[1:0]] = 1'b1;
    return s;
  endfunction
endpackage

// File: rtl/synth_div.sv
module synth_div #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] lim_i,
  output logic         pulse_o
);
  logic [W-1:0] cnt_q;
  logic         pulse_q;

  // Down counter; the ratio is sampled only when the count ends.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= tick_i && (cnt_q == '0);
      if (tick_i) begin
        if (cnt_q == '0) cnt_q <= lim_i - W'(1);
        else             cnt_q <= cnt_q - W'(1);
      end
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/synth_pfd.sv
module synth_pfd (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_ev_i,
  input  logic fb_ev_i,
  output logic up_o,
  output logic dn_o
);
  logic up_q, dn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (up_q && dn_q) begin
      up_q <= 1'b0;  // clearing cycle, events ignored
      dn_q <= 1'b0;
    end else begin
      up_q <= up_q | ref_ev_i;
      dn_q <= dn_q | fb_ev_i;
    end
  end

  assign up_o = up_q;
  assign dn_o = dn_q;
endmodule

// File: rtl/synth_lock.sv
module synth_lock #(
  parameter int ERR_W  = 8,
  parameter int LOCK_N = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             up_i,
  input  logic             dn_i,
  input  logic [ERR_W-1:0] limit_i,
  output logic             lock_o
);
  localparam int GW = $clog2(LOCK_N + 1);
  localparam logic [GW-1:0] GOOD_MAX = GW'(LOCK_N);
  localparam logic [GW-1:0] GOOD_SET = GW'(LOCK_N - 1);

  logic [ERR_W-1:0] err_q;
  logic [GW-1:0]    good_q;
  logic             bad_q, lock_q;
  logic             excl, both;

  assign excl = up_i ^ dn_i;
  assign both = up_i & dn_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= '0;
      good_q <= '0;
      bad_q  <= 1'b0;
      lock_q <= 1'b0;
    end else if (both) begin
      // Period end: score it unless it already failed.
      if (!bad_q) begin
        if (good_q >= GOOD_SET) lock_q <= 1'b1;
        if (good_q != GOOD_MAX) good_q <= good_q + GW'(1);
      end
      err_q <= '0;
      bad_q <= 1'b0;
    end else if (excl && !bad_q) begin
      if (err_q >= limit_i) begin
        bad_q  <= 1'b1;
        lock_q <= 1'b0;
        good_q <= '0;
      end else begin
        err_q <= err_q + ERR_W'(1);
      end
    end
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/synth_core.sv
module synth_core #(
  parameter int N_W    = 15,
  parameter int N_MIN  = 512,
  parameter int ERR_W  = 8,
  parameter int LOCK_N = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       ref_tick_i,
  input  logic                       fb_tick_i,
  input  logic [N_W-1:0]             n_word_i,
  input  logic [2:0]                 ref_sel_i,
  input  logic [2:0]                 cp_sel_i,
  input  logic                       cp_mode_i,
  input  logic [ERR_W-1:0]           err_limit_i,
  output logic                       ref_pulse_o,
  output logic                       fb_pulse_o,
  output logic                       up_o,
  output logic                       dn_o,
  output logic                       lock_o,
  output logic                       ref_rsv_o,
  output logic [synth_pkg::PUMP_N-1:0] pump_sel_o
);
  import synth_pkg::*;

  localparam logic [N_W-1:0] N_FLOOR = N_W'(N_MIN);

  logic [REF_W-1:0] ref_lim;
  logic [N_W-1:0]   fb_lim;

  assign ref_lim   = ref_ratio(ref_sel_i);
  assign ref_rsv_o = (ref_sel_i == 3'b110);
  assign fb_lim    = (n_word_i < N_FLOOR) ? N_FLOOR : n_word_i;
  assign pump_sel_o = pump_onehot(cp_sel_i, cp_mode_i);

  synth_div #(.W(REF_W)) u_ref_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (ref_tick_i),
    .lim_i   (ref_lim),
    .pulse_o (ref_pulse_o)
  );

  synth_div #(.W(N_W)) u_fb_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (fb_tick_i),
    .lim_i   (fb_lim),
    .pulse_o (fb_pulse_o)
  );

  synth_pfd u_pfd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ref_ev_i (ref_pulse_o),
    .fb_ev_i  (fb_pulse_o),
    .up_o     (up_o),
    .dn_o     (dn_o)
  );

  synth_lock #(.ERR_W(ERR_W), .LOCK_N(LOCK_N)) u_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .up_i    (up_o),
    .dn_i    (dn_o),
    .limit_i (err_limit_i),
    .lock_o  (lock_o)
  );
endmodule

// File: rtl/synth_core_chk.sv
module synth_core_chk #(
  parameter int N_MIN = 512
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ref_tick_i,
  input logic       fb_pulse_o,
  input logic       ref_pulse_o,
  input logic       up_o,
  input logic       dn_o,
  input logic       lock_o,
  input logic [4:0] pump_sel_o
);
  logic [15:0] since_q;
  logic        seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else if (fb_pulse_o) begin
      since_q <= '0;
      seen_q  <= 1'b1;
    end else if (since_q != 16'hffff) begin
      since_q <= since_q + 16'd1;
    end
  end

  AST_FB_MIN_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fb_pulse_o && seen_q) |-> (32'(since_q) + 1 >= N_MIN)); // R3
  AST_REF_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_pulse_o |-> $past(ref_tick_i)); // R4
  AST_PFD_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_o && dn_o) |=> (!up_o && !dn_o)); // R5
  AST_LOCK_AT_PERIOD_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(up_o && dn_o)); // R6
  AST_PUMP_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(pump_sel_o)); // R8
endmodule

bind synth_core synth_core_chk #(.N_MIN(N_MIN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ref_tick_i  (ref_tick_i),
  .fb_pulse_o  (fb_pulse_o),
  .ref_pulse_o (ref_pulse_o),
  .up_o        (up_o),
  .dn_o        (dn_o),
  .lock_o      (lock_o),
  .pump_sel_o  (pump_sel_o)
);

// File: tb/synth_core_tb_top.sv
`timescale 1ns/1ps
module synth_core_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ref_tick_i = 1'b0;
  logic        fb_tick_i = 1'b0;
  logic [14:0] n_word_i = '0;
  logic [2:0]  ref_sel_i = '0;
  logic [2:0]  cp_sel_i = '0;
  logic        cp_mode_i = 1'b0;
  logic [7:0]  err_limit_i = '0;
  logic        ref_pulse_o, fb_pulse_o, up_o, dn_o, lock_o, ref_rsv_o;
  logic [4:0]  pump_sel_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  synth_core dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_tick_i(ref_tick_i), .fb_tick_i(fb_tick_i),
    .n_word_i(n_word_i), .ref_sel_i(ref_sel_i), .cp_sel_i(cp_sel_i), .cp_mode_i(cp_mode_i),
    .err_limit_i(err_limit_i), .ref_pulse_o(ref_pulse_o), .fb_pulse_o(fb_pulse_o),
    .up_o(up_o), .dn_o(dn_o), .lock_o(lock_o), .ref_rsv_o(ref_rsv_o), .pump_sel_o(pump_sel_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    ref_tick_i = 1'b0;
    fb_tick_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic wait_ref();
    do @(negedge clk_i); while (!ref_pulse_o);
  endtask

  task automatic gap_ref(output int g);
    g = 0;
    do begin @(negedge clk_i); g++; end while (!ref_pulse_o);
  endtask

  task automatic wait_fb();
    do @(negedge clk_i); while (!fb_pulse_o);
  endtask

  task automatic gap_fb(output int g);
    g = 0;
    do begin @(negedge clk_i); g++; end while (!fb_pulse_o);
  endtask

  function automatic int exp_ratio(input int code);
    case (code)
      0: return 24;
      1: return 28;
      2: return 32;
      3: return 64;
      4: return 128;
      6: return 128;
      default: return 80;
    endcase
  endfunction

  initial begin
    int g;
    int pw;
    int nlist[6];
    int nexp;
    int dn_only, up_only, both_n;
    bit seen_both;

    // R10 reset state
    rst_ni = 1'b0;
    ref_tick_i = 1'b1;
    fb_tick_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(!ref_pulse_o && !fb_pulse_o, "R10 pulses in reset", int'(ref_pulse_o | fb_pulse_o), 0);
    chk(!up_o && !dn_o, "R10 detector in reset", int'({up_o, dn_o}), 0);
    chk(!lock_o, "R10 lock in reset", int'(lock_o), 0);

    // R8 R9 pump decode sweep
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 8; c++) begin
        cp_mode_i = m[0];
        cp_sel_i = c[2:0];
        #1;
        pw = (m == 1 && c == 4) ? 16 : (1 << (c % 4));
        chk(pump_sel_o == pw[4:0], (m == 1 && c[2]) ? "R9 pump decode" : "R8 pump decode",
            int'(pump_sel_o), pw);
      end
    end

    // R2 reserved flag
    for (int c = 0; c < 8; c++) begin
      ref_sel_i = c[2:0];
      #1;
      chk(ref_rsv_o == (c == 6), "R2 reserved flag", int'(ref_rsv_o), int'(c == 6));
    end

    // R4 first strobe pulses at once; R1 R2 ratio sweep
    do_reset();
    ref_sel_i = 3'd0;
    ref_tick_i = 1'b1;
    @(negedge clk_i);
    chk(ref_pulse_o, "R4 first strobe pulse", int'(ref_pulse_o), 1);
    for (int c = 0; c < 8; c++) begin
      ref_sel_i = c[2:0];
      wait_ref();
      gap_ref(g);
      chk(g == exp_ratio(c), (c == 6) ? "R2 reserved ratio" : "R1 ref ratio", g, exp_ratio(c));
    end

    // R4 mid-period change waits for terminal count
    ref_sel_i = 3'd0;
    wait_ref();
    ref_sel_i = 3'd4;
    gap_ref(g);
    chk(g == 24, "R4 old ratio holds", g, 24);
    gap_ref(g);
    chk(g == 128, "R4 new ratio after terminal", g, 128);
    ref_tick_i = 1'b0;

    // R3 feedback ratios, floor and top
    nlist = '{512, 600, 0, 511, 1000, 32767};
    fb_tick_i = 1'b1;
    for (int i = 0; i < 6; i++) begin
      n_word_i = nlist[i][14:0];
      nexp = (nlist[i] < 512) ? 512 : nlist[i];
      wait_fb();
      gap_fb(g);
      chk(g == nexp, "R3 feedback ratio", g, nexp);
    end
    fb_tick_i = 1'b0;

    // R5 ref leads feedback by 6 cycles
    do_reset();
    ref_sel_i = 3'd0;
    n_word_i = 15'd512;
    up_only = 0; dn_only = 0; both_n = 0;
    for (int c = 0; c < 21; c++) begin
      ref_tick_i = 1'b1;
      fb_tick_i = (c >= 6);
      @(negedge clk_i);
      if (up_o && !dn_o) up_only++;
      if (dn_o && !up_o) dn_only++;
      if (up_o && dn_o) both_n++;
    end
    chk(up_only == 6, "R5 up width", up_only, 6);
    chk(dn_only == 0, "R5 no down", dn_only, 0);
    chk(both_n == 1, "R5 one overlap cycle", both_n, 1);

    // R6 R7 lock: ref lags feedback by p cycles, limit 3
    do_reset();
    ref_sel_i = 3'd2;
    n_word_i = 15'd512;
    err_limit_i = 8'd3;
    pw = 3;
    up_only = 0; dn_only = 0; both_n = 0;
    seen_both = 1'b0;
    for (int c = 0; c < 512 * 12 + 300; c++) begin
      ref_tick_i = ((c % 16) == pw);
      fb_tick_i = 1'b1;
      @(negedge clk_i);
      if (c == 512 * 2 + 256) chk(!lock_o, "R6 no lock after 3 periods", int'(lock_o), 0);
      if (c == 512 * 3 + 256) chk(lock_o, "R6 lock at limit after 4", int'(lock_o), 1);
      if (c == 512 * 4 + 256) pw = 4;
      if (c > 512 * 5 && c < 512 * 5 + 100 && up_o && dn_o && !seen_both) begin
        seen_both = 1'b1;
        chk(!lock_o, "R7 lock cleared before period end", int'(lock_o), 0);
      end
      if (c == 512 * 5 + 256) chk(!lock_o, "R7 lock cleared", int'(lock_o), 0);
      if (c >= 512 * 6 + 100 && c < 512 * 7 + 100) begin
        if (up_o && !dn_o) up_only++;
        if (dn_o && !up_o) dn_only++;
        if (up_o && dn_o) both_n++;
      end
      if (c == 512 * 7 + 100) begin
        chk(dn_only == 4, "R5 down width", dn_only, 4);
        chk(up_only == 0, "R5 no up", up_only, 0);
        chk(both_n == 1, "R5 overlap per period", both_n, 1);
      end
      if (c == 512 * 8 + 200) chk(!lock_o, "R7 stays unlocked", int'(lock_o), 0);
      if (c == 512 * 8 + 256) pw = 2;
      if (c == 512 * 11 + 256) chk(!lock_o, "R6 relock needs 4", int'(lock_o), 0);
      if (c == 512 * 12 + 256) chk(lock_o, "R6 relock", int'(lock_o), 1);
    end
    chk(seen_both, "R7 overlap seen", int'(seen_both), 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule